// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block sits between a UART's serial receiver and its receive FIFO, and between the transmit FIFO and the serial transmitter. It adds in-band XON/XOFF flow control. Each received character is compared with four programmed flow characters: an XON pair and an XOFF pair. A recognised XOFF pauses the transmitter's FIFO traffic and a recognised XON resumes it. Recognised flow characters are consumed. All other characters go on to the receive FIFO one cycle later. On the transmit side, a throttle request from the receive FIFO makes the block insert the selected XOFF (or XON, when the request drops) ahead of FIFO data at the next character boundary.

A control register selects the receive and transmit flow modes and enables special-character detection. Its unlock bit gates writes to the enhanced fields of the interrupt-enable, FIFO-control, modem-control and status registers. Those fields keep their values while the unlock bit is 0, and all registers clear on reset. Configuration uses a simple write strobe with an address: 0 control, 1 XON-A, 2 XON-B, 3 XOFF-A, 4 XOFF-B, 5 interrupt enable, 6 FIFO control, 7 modem control, 8 status. The receiver must leave at least one idle cycle between two `rxValid` pulses.

Top module: `swfc_top`

## Requirements
- R1: After reset, every register output reads 0, `txPaused` is 0, `fifoWe` is 0 and `irq` is 0.
- R2: While control bit 4 is 0, writes leave interrupt-enable bits 7:4, FIFO-control bits 5:4, modem-control bits 7:5 and status bits 5:4 unchanged, and the other bits of those registers are still written. While bit 4 is 1, every bit is written.
- R3: With receive mode (control bits 1:0) 00, every received byte is written to the FIFO on the cycle after `rxValid`, and `txPaused` never changes.
- R4: With receive mode 01, XON-B resumes and XOFF-B pauses. Both are consumed. Any other byte, XON-A included, is forwarded.
- R5: With receive mode 10, XON-A resumes and XOFF-A pauses. Both are consumed.
- R6: With receive mode 11 and transmit mode (control bits 3:2) 01 or 10, either XON character resumes and either XOFF character pauses. All four are consumed.
- R7: With receive mode 11 and transmit mode 00 or 11, only the in-order pairs XON-A,XON-B and XOFF-A,XOFF-B act, and both bytes of a pair are consumed. If the first byte of a pair is followed by a byte that does not complete it, the first byte is forwarded and the second byte is evaluated afresh, so it may start a new pair.
- R8: With control bit 5 set, a received byte equal to XOFF-B sets status bit 4. In receive mode 10 that byte is still forwarded. In receive mode 01 it is consumed, pauses the transmitter and also sets status bit 5, the XOFF flag. Both flags stay set until written.
- R9: While paused, no FIFO data is loaded into the transmitter (`fifoTxPop` stays 0). Loading resumes after XON.
- R10: `txLoad` only fires with `txReady`. When `throttleReq` differs from the last state sent and transmit mode is not 00, the next load is a flow character: XOFF-B/XON-B for mode 01, XOFF-A/XON-A for mode 10, and XOFF-A then XOFF-B (or XON-A then XON-B) on consecutive loads for mode 11. Inserted characters win over FIFO data and are sent even while paused.
- R11: `irq` is 1 exactly when status bit 4 and interrupt-enable bit 4, or status bit 5 and interrupt-enable bit 5, are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | ADDR_W | Register address |
| cfgWdata | input | DATA_W | Register write data |
| rxValid | input | 1 | Received character valid (one cycle) |
| rxData | input | DATA_W | Received character |
| fifoWe | output | 1 | Receive FIFO write |
| fifoWdata | output | DATA_W | Receive FIFO write data |
| throttleReq | input | 1 | 1 asks the far end to stop, 0 to run |
| fifoTxValid | input | 1 | Transmit FIFO holds a character |
| fifoTxData | input | DATA_W | Transmit FIFO head character |
| fifoTxPop | output | 1 | Transmit FIFO head consumed |
| txReady | input | 1 | Transmit shifter can take a character |
| txLoad | output | 1 | Character handed to the shifter |
| txChar | output | DATA_W | Character for the shifter |
| txPaused | output | 1 | Transmitter held by a received XOFF |
| ctrlOut | output | DATA_W | Control register |
| ierOut | output | DATA_W | Interrupt-enable register |
| fcrOut | output | DATA_W | FIFO-control register |
| mcrOut | output | DATA_W | Modem-control register |
| statOut | output | DATA_W | Status register (bits 5:4) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit characters and a 4-bit register address. These widths let the flow characters be set to 0x11..0x14, so random data can be drawn from the whole byte space outside those four codes. The random phase runs in the two-byte pair mode with a mix of pair starts, pair completions and plain data. This reaches broken pairs, repeated first bytes and replays that start a new pair. Directed cases cover each mode pairing, the lock, the special character and transmit insertion while paused.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int NUM_FLOW = 4;

  localparam logic [1:0] SEL_XON_A  = 2'd0;
  localparam logic [1:0] SEL_XON_B  = 2'd1;
  localparam logic [1:0] SEL_XOFF_A = 2'd2;
  localparam logic [1:0] SEL_XOFF_B = 2'd3;

  localparam int ADR_CTRL = 0;
  localparam int ADR_FLOW = 1;
  localparam int ADR_IER  = 5;
  localparam int ADR_FCR  = 6;
  localparam int ADR_MCR  = 7;
  localparam int ADR_STAT = 8;

  localparam int BIT_UNLOCK = 4;
  localparam int BIT_SPEC   = 5;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_SETB = 2'b01,
    MODE_SETA = 2'b10,
    MODE_BOTH = 2'b11
  } flowMode_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON   = 2'd1,
    PEND_OFF  = 2'd2
  } pend_e;

  typedef struct packed {
    logic xonA;
    logic xonB;
    logic xoffA;
    logic xoffB;
  } charMatch_t;

  typedef struct packed {
    logic       fwdCur;
    logic       fwdHeld;
    logic       loadHeld;
    logic       loadReplay;
    logic       setSpec;
    logic       setXoff;
    logic       txInsert;
    logic       txData;
    logic [1:0] txSel;
  } strobe_t;
endpackage

// File: rtl/swfc_dp.sv
module swfc_dp
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [DATA_W-1:0]          cfgWdata,
  input  logic                       rxValid,
  input  logic [DATA_W-1:0]          rxData,
  input  logic [DATA_W-1:0]          fifoTxData,
  input  strobe_t                    stb,
  output logic                       curValid,
  output charMatch_t                 match,
  output logic                       replayPending,
  output logic [NUM_FLOW*DATA_W-1:0] flowChars,
  output logic                       fifoWe,
  output logic [DATA_W-1:0]          fifoWdata,
  output logic                       txLoad,
  output logic                       fifoTxPop,
  output logic [DATA_W-1:0]          txChar,
  output logic [DATA_W-1:0]          ctrlReg,
  output logic [DATA_W-1:0]          ierReg,
  output logic [DATA_W-1:0]          fcrReg,
  output logic [DATA_W-1:0]          mcrReg,
  output logic [DATA_W-1:0]          statReg,
  output logic                       irq
);
  localparam logic [DATA_W-1:0] IER_ENH = DATA_W'(8'hF0);
  localparam logic [DATA_W-1:0] FCR_ENH = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] MCR_ENH = DATA_W'(8'hE0);

  logic [NUM_FLOW-1:0][DATA_W-1:0] flowReg;
  logic [NUM_FLOW-1:0]             hit;
  logic [DATA_W-1:0]               curByte, heldByte, replayByte;
  logic                            replayValid;
  logic                            specFlag, xoffFlag;
  logic                            unlock;

  assign unlock = ctrlReg[BIT_UNLOCK];

  function automatic logic [DATA_W-1:0] lockedWrite(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [DATA_W-1:0] enhMask,
    input logic              open
  );
    return open ? newVal : ((newVal & ~enhMask) | (oldVal & enhMask));
  endfunction

  function automatic logic hitAddr(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ierReg  <= '0;
      fcrReg  <= '0;
      mcrReg  <= '0;
      flowReg <= '0;
    end else if (cfgWe) begin
      if (hitAddr(cfgAddr, ADR_CTRL)) ctrlReg <= cfgWdata;
      if (hitAddr(cfgAddr, ADR_IER))  ierReg  <= lockedWrite(ierReg, cfgWdata, IER_ENH, unlock);
      if (hitAddr(cfgAddr, ADR_FCR))  fcrReg  <= lockedWrite(fcrReg, cfgWdata, FCR_ENH, unlock);
      if (hitAddr(cfgAddr, ADR_MCR))  mcrReg  <= lockedWrite(mcrReg, cfgWdata, MCR_ENH, unlock);
      for (int i = 0; i < NUM_FLOW; i++) begin
        if (hitAddr(cfgAddr, ADR_FLOW + i)) flowReg[i] <= cfgWdata;
      end
    end
  end

  // status flags: hardware set wins over a software write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      specFlag <= 1'b0;
      xoffFlag <= 1'b0;
    end else begin
      if (stb.setSpec) specFlag <= 1'b1;
      else if (cfgWe && unlock && hitAddr(cfgAddr, ADR_STAT)) specFlag <= cfgWdata[4];
      if (stb.setXoff) xoffFlag <= 1'b1;
      else if (cfgWe && unlock && hitAddr(cfgAddr, ADR_STAT)) xoffFlag <= cfgWdata[5];
    end
  end

  assign statReg = DATA_W'({xoffFlag, specFlag, 4'b0000});
  assign irq     = (specFlag & ierReg[4]) | (xoffFlag & ierReg[5]);

  // current receive character: a replayed byte or the live one
  assign curValid      = rxValid | replayValid;
  assign curByte       = replayValid ? replayByte : rxData;
  assign replayPending = replayValid;

  generate
    for (genvar gi = 0; gi < NUM_FLOW; gi++) begin : gCmp
      assign hit[gi] = curValid && (curByte == flowReg[gi]);
    end
  endgenerate

  assign match = '{xonA:  hit[SEL_XON_A],  xonB:  hit[SEL_XON_B],
                   xoffA: hit[SEL_XOFF_A], xoffB: hit[SEL_XOFF_B]};
  assign flowChars = flowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replayValid <= 1'b0;
      replayByte  <= '0;
      heldByte    <= '0;
      fifoWe      <= 1'b0;
      fifoWdata   <= '0;
    end else begin
      replayValid <= stb.loadReplay;
      if (stb.loadReplay) replayByte <= curByte;
      if (stb.loadHeld)   heldByte   <= curByte;
      fifoWe <= stb.fwdCur | stb.fwdHeld;
      if (stb.fwdHeld)     fifoWdata <= heldByte;
      else if (stb.fwdCur) fifoWdata <= curByte;
    end
  end

  // transmit character selection
  assign txChar    = stb.txInsert ? flowReg[stb.txSel] : fifoTxData;
  assign txLoad    = stb.txInsert | stb.txData;
  assign fifoTxPop = stb.txData;
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  flowMode_e  rxMode,
  input  flowMode_e  txMode,
  input  logic       specEn,
  input  logic       curValid,
  input  charMatch_t match,
  input  logic       txReady,
  input  logic       fifoTxValid,
  input  logic       throttleReq,
  output strobe_t    stb,
  output logic       txPaused,
  output logic [1:0] pendState
);
  pend_e pendQ, pendNext;
  logic  pausedQ, pausedNext;
  logic  secondQ, secondNext;
  logic  seqOffQ, seqOffNext;
  logic  farStopQ, farStopNext;
  logic  xonEv, xoffEv;
  logic  singleCmp;

  // in receive mode 11, transmit modes 01/10 compare single characters
  assign singleCmp = (txMode == MODE_SETA) || (txMode == MODE_SETB);

  always_comb begin
    stb         = '0;
    pendNext    = pendQ;
    pausedNext  = pausedQ;
    secondNext  = secondQ;
    seqOffNext  = seqOffQ;
    farStopNext = farStopQ;
    xonEv       = 1'b0;
    xoffEv      = 1'b0;

    if (curValid) begin
      stb.setSpec = specEn && match.xoffB;
      case (pendQ)
        PEND_ON: begin
          pendNext = PEND_NONE;
          if (match.xonB) xonEv = 1'b1;
          else begin
            stb.fwdHeld    = 1'b1;
            stb.loadReplay = 1'b1;
          end
        end
        PEND_OFF: begin
          pendNext = PEND_NONE;
          if (match.xoffB) xoffEv = 1'b1;
          else begin
            stb.fwdHeld    = 1'b1;
            stb.loadReplay = 1'b1;
          end
        end
        default: begin
          case (rxMode)
            MODE_SETB: begin
              if (match.xoffB)     xoffEv = 1'b1;
              else if (match.xonB) xonEv  = 1'b1;
              else                 stb.fwdCur = 1'b1;
            end
            MODE_SETA: begin
              if (match.xoffA)     xoffEv = 1'b1;
              else if (match.xonA) xonEv  = 1'b1;
              else                 stb.fwdCur = 1'b1;
            end
            MODE_BOTH: begin
              if (singleCmp) begin
                if (match.xoffA || match.xoffB)   xoffEv = 1'b1;
                else if (match.xonA || match.xonB) xonEv = 1'b1;
                else                               stb.fwdCur = 1'b1;
              end else if (match.xoffA) begin
                stb.loadHeld = 1'b1;
                pendNext     = PEND_OFF;
              end else if (match.xonA) begin
                stb.loadHeld = 1'b1;
                pendNext     = PEND_ON;
              end else begin
                stb.fwdCur = 1'b1;
              end
            end
            default: stb.fwdCur = 1'b1;
          endcase
        end
      endcase
    end

    stb.setXoff = xoffEv;
    if (xoffEv)     pausedNext = 1'b1;
    else if (xonEv) pausedNext = 1'b0;

    // transmit: second half of a pair, then a new flow request, then data
    if (txReady) begin
      if (secondQ) begin
        stb.txInsert = 1'b1;
        stb.txSel    = seqOffQ ? SEL_XOFF_B : SEL_XON_B;
        secondNext   = 1'b0;
      end else if ((txMode != MODE_OFF) && (throttleReq != farStopQ)) begin
        stb.txInsert = 1'b1;
        farStopNext  = throttleReq;
        seqOffNext   = throttleReq;
        if (txMode == MODE_SETB) stb.txSel = throttleReq ? SEL_XOFF_B : SEL_XON_B;
        else                     stb.txSel = throttleReq ? SEL_XOFF_A : SEL_XON_A;
        secondNext = (txMode == MODE_BOTH);
      end else if (!pausedQ && fifoTxValid) begin
        stb.txData = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= PEND_NONE;
      pausedQ  <= 1'b0;
      secondQ  <= 1'b0;
      seqOffQ  <= 1'b0;
      farStopQ <= 1'b0;
    end else begin
      pendQ    <= pendNext;
      pausedQ  <= pausedNext;
      secondQ  <= secondNext;
      seqOffQ  <= seqOffNext;
      farStopQ <= farStopNext;
    end
  end

  assign txPaused  = pausedQ;
  assign pendState = pendQ;
endmodule

// File: rtl/swfc_top.sv
module swfc_top
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              fifoWe,
  output logic [DATA_W-1:0] fifoWdata,
  input  logic              throttleReq,
  input  logic              fifoTxValid,
  input  logic [DATA_W-1:0] fifoTxData,
  output logic              fifoTxPop,
  input  logic              txReady,
  output logic              txLoad,
  output logic [DATA_W-1:0] txChar,
  output logic              txPaused,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] ierOut,
  output logic [DATA_W-1:0] fcrOut,
  output logic [DATA_W-1:0] mcrOut,
  output logic [DATA_W-1:0] statOut,
  output logic              irq
);
  strobe_t                    stb;
  charMatch_t                 match;
  logic                       curValid;
  logic                       replayPending;
  logic [NUM_FLOW*DATA_W-1:0] flowChars;
  logic [1:0]                 pendState;
  logic [DATA_W-1:0]          xoffAChar, xoffBChar;
  flowMode_e                  rxMode, txMode;
  logic                       specEn, unlockEn;

  assign rxMode    = flowMode_e'(ctrlOut[1:0]);
  assign txMode    = flowMode_e'(ctrlOut[3:2]);
  assign specEn    = ctrlOut[BIT_SPEC];
  assign unlockEn  = ctrlOut[BIT_UNLOCK];
  assign xoffAChar = flowChars[SEL_XOFF_A*DATA_W +: DATA_W];
  assign xoffBChar = flowChars[SEL_XOFF_B*DATA_W +: DATA_W];

  swfc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxValid(rxValid), .rxData(rxData), .fifoTxData(fifoTxData),
    .stb(stb), .curValid(curValid), .match(match),
    .replayPending(replayPending), .flowChars(flowChars),
    .fifoWe(fifoWe), .fifoWdata(fifoWdata),
    .txLoad(txLoad), .fifoTxPop(fifoTxPop), .txChar(txChar),
    .ctrlReg(ctrlOut), .ierReg(ierOut), .fcrReg(fcrOut), .mcrReg(mcrOut),
    .statReg(statOut), .irq(irq)
  );

  swfc_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .rxMode(rxMode), .txMode(txMode), .specEn(specEn),
    .curValid(curValid), .match(match),
    .txReady(txReady), .fifoTxValid(fifoTxValid), .throttleReq(throttleReq),
    .stb(stb), .txPaused(txPaused), .pendState(pendState)
  );
endmodule

// File: rtl/swfc_chk.sv
module swfc_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic [1:0]        rxMode,
  input logic              specEn,
  input logic              unlockEn,
  input logic [DATA_W-1:0] xoffAChar,
  input logic [DATA_W-1:0] xoffBChar,
  input logic [1:0]        pendState,
  input logic              replayPending,
  input logic              txPaused,
  input logic              txLoad,
  input logic              txReady,
  input logic              fifoTxPop,
  input logic              fifoWe,
  input logic [3:0]        ierEnh,
  input logic [1:0]        fcrEnh,
  input logic [2:0]        mcrEnh,
  input logic              specFlag
);
  AST_LOAD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> txReady); // R10

  AST_PAUSE_HOLDS_FIFO: assert property (@(posedge clk) disable iff (!rstN)
    txPaused |-> !fifoTxPop); // R9

  AST_LOCK_KEEPS_ENH: assert property (@(posedge clk) disable iff (!rstN)
    !unlockEn |=> ($stable(ierEnh) && $stable(fcrEnh) && $stable(mcrEnh))); // R2

  AST_SETA_XOFF_PAUSES: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !replayPending && rxMode == 2'b10 && pendState == 2'd0 && rxData == xoffAChar)
      |=> txPaused); // R5

  AST_SETB_XOFF_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !replayPending && rxMode == 2'b01 && pendState == 2'd0 && rxData == xoffBChar)
      |=> (!fifoWe && txPaused)); // R4

  AST_SPECIAL_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !replayPending && specEn && rxData == xoffBChar) |=> specFlag); // R8
endmodule

bind swfc_top swfc_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
  .rxMode(ctrlOut[1:0]), .specEn(specEn), .unlockEn(unlockEn),
  .xoffAChar(xoffAChar), .xoffBChar(xoffBChar),
  .pendState(pendState), .replayPending(replayPending),
  .txPaused(txPaused), .txLoad(txLoad), .txReady(txReady), .fifoTxPop(fifoTxPop),
  .fifoWe(fifoWe), .ierEnh(ierOut[7:4]), .fcrEnh(fcrOut[5:4]), .mcrEnh(mcrOut[7:5]),
  .specFlag(statOut[4])
);

// File: tb/tb_swfc_top.sv
module tb_swfc_top;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CLK_HALF = 4;

  localparam logic [7:0] XON_A  = 8'h11;
  localparam logic [7:0] XON_B  = 8'h12;
  localparam logic [7:0] XOFF_A = 8'h13;
  localparam logic [7:0] XOFF_B = 8'h14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [DATA_W-1:0] cfgWdata = '0;
  logic              rxValid = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic              fifoWe;
  logic [DATA_W-1:0] fifoWdata;
  logic              throttleReq = 1'b0;
  logic              fifoTxValid = 1'b0;
  logic [DATA_W-1:0] fifoTxData = '0;
  logic              fifoTxPop;
  logic              txReady = 1'b0;
  logic              txLoad;
  logic [DATA_W-1:0] txChar;
  logic              txPaused;
  logic [DATA_W-1:0] ctrlOut, ierOut, fcrOut, mcrOut, statOut;
  logic              irq;

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0] got[$];
  logic [7:0] expQ[$];
  int         mPend = 0;
  logic [7:0] mHeld = '0;
  logic       mPaused = 1'b0;

  always #CLK_HALF clk = ~clk;

  swfc_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxValid(rxValid), .rxData(rxData), .fifoWe(fifoWe), .fifoWdata(fifoWdata),
    .throttleReq(throttleReq), .fifoTxValid(fifoTxValid), .fifoTxData(fifoTxData),
    .fifoTxPop(fifoTxPop), .txReady(txReady), .txLoad(txLoad), .txChar(txChar),
    .txPaused(txPaused), .ctrlOut(ctrlOut), .ierOut(ierOut), .fcrOut(fcrOut),
    .mcrOut(mcrOut), .statOut(statOut), .irq(irq)
  );

  always @(negedge clk) if (rstN && fifoWe) got.push_back(fifoWdata);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrCfg(input int addr, input logic [7:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = ADDR_W'(addr); cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkGot(input string req, input int n, input logic [7:0] b0, input logic [7:0] b1);
    check(req, "fifo write count", got.size(), n);
    if (n > 0 && got.size() > 0) check(req, "fifo byte 0", got[0], b0);
    if (n > 1 && got.size() > 1) check(req, "fifo byte 1", got[1], b1);
    got.delete();
  endtask

  // bench model of the pair-matching receive mode
  task automatic modelByte(input logic [7:0] b);
    logic [7:0] cur;
    bit again;
    cur = b;
    again = 1'b1;
    while (again) begin
      again = 1'b0;
      if (mPend == 0) begin
        if (cur == XOFF_A)     begin mPend = 2; mHeld = cur; end
        else if (cur == XON_A) begin mPend = 1; mHeld = cur; end
        else expQ.push_back(cur);
      end else if (mPend == 1 && cur == XON_B) begin
        mPaused = 1'b0; mPend = 0;
      end else if (mPend == 2 && cur == XOFF_B) begin
        mPaused = 1'b1; mPend = 0;
      end else begin
        expQ.push_back(mHeld); mPend = 0; again = 1'b1;
      end
    end
  endtask

  function automatic logic [7:0] plainByte();
    logic [7:0] v;
    v = 8'($urandom);
    if (v >= XON_A && v <= XOFF_B) v = v ^ 8'h40;
    return v;
  endfunction

  initial begin
    #(2 * CLK_HALF * 150000);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "ctrlOut", ctrlOut, 0);
    check("R1", "ierOut", ierOut, 0);
    check("R1", "fcrOut", fcrOut, 0);
    check("R1", "mcrOut", mcrOut, 0);
    check("R1", "statOut", statOut, 0);
    check("R1", "txPaused", txPaused, 0);
    check("R1", "fifoWe", fifoWe, 0);
    check("R1", "irq", irq, 0);

    // R2 lock on enhanced fields
    wrCfg(5, 8'hFF); check("R2", "ier locked", ierOut, 8'h0F);
    wrCfg(6, 8'hFF); check("R2", "fcr locked", fcrOut, 8'hCF);
    wrCfg(7, 8'hFF); check("R2", "mcr locked", mcrOut, 8'h1F);
    wrCfg(0, 8'h10);
    wrCfg(5, 8'hFF); check("R2", "ier unlocked", ierOut, 8'hFF);
    wrCfg(0, 8'h00);
    wrCfg(5, 8'h00); check("R2", "ier relocked", ierOut, 8'hF0);

    wrCfg(1, XON_A); wrCfg(2, XON_B); wrCfg(3, XOFF_A); wrCfg(4, XOFF_B);
    got.delete();

    // R3 no receive flow control, one-cycle write latency
    @(negedge clk); rxValid = 1'b1; rxData = XOFF_A;
    @(negedge clk); rxValid = 1'b0;
    check("R3", "fifoWe one cycle after rxValid", fifoWe, 1);
    repeat (3) @(negedge clk);
    checkGot("R3", 1, XOFF_A, 0);
    check("R3", "no pause", txPaused, 0);

    // R4 set B compare
    wrCfg(0, 8'h01);
    sendRx(XOFF_B); checkGot("R4", 0, 0, 0); check("R4", "paused", txPaused, 1);
    sendRx(XON_A);  checkGot("R4", 1, XON_A, 0); check("R4", "still paused", txPaused, 1);
    sendRx(XON_B);  checkGot("R4", 0, 0, 0); check("R4", "resumed", txPaused, 0);

    // R5 set A compare
    wrCfg(0, 8'h02);
    sendRx(XOFF_A); checkGot("R5", 0, 0, 0); check("R5", "paused", txPaused, 1);
    sendRx(XON_A);  checkGot("R5", 0, 0, 0); check("R5", "resumed", txPaused, 0);

    // R6 either character with transmit mode 10
    wrCfg(0, 8'h0B);
    sendRx(XOFF_B); checkGot("R6", 0, 0, 0); check("R6", "paused", txPaused, 1);
    sendRx(XON_A);  checkGot("R6", 0, 0, 0); check("R6", "resumed", txPaused, 0);

    // R7 pair mode with transmit mode 00
    wrCfg(0, 8'h03);
    sendRx(XOFF_A); checkGot("R7", 0, 0, 0); check("R7", "half pair no pause", txPaused, 0);
    sendRx(XOFF_B); checkGot("R7", 0, 0, 0); check("R7", "pair paused", txPaused, 1);
    sendRx(XON_A); sendRx(8'h55);
    checkGot("R7", 2, XON_A, 8'h55); check("R7", "broken pair keeps pause", txPaused, 1);
    sendRx(XON_A); sendRx(XON_A); sendRx(XON_B);
    checkGot("R7", 1, XON_A, 0); check("R7", "replayed first byte pairs", txPaused, 0);

    // R8 special character, R11 interrupt
    wrCfg(0, 8'h22);
    sendRx(XOFF_B); checkGot("R8", 1, XOFF_B, 0);
    check("R8", "spec flag", statOut[4], 1);
    check("R8", "mode 10 no pause", txPaused, 0);
    check("R11", "irq set", irq, 1);
    wrCfg(0, 8'h32); wrCfg(8, 8'h00);
    check("R2", "status cleared when unlocked", statOut, 0);
    check("R11", "irq clear", irq, 0);
    wrCfg(0, 8'h21);
    sendRx(XOFF_B); checkGot("R8", 0, 0, 0);
    check("R8", "spec and xoff flags", statOut, 8'h30);
    check("R8", "mode 01 paused", txPaused, 1);
    sendRx(XON_B); check("R8", "resumed", txPaused, 0);

    // R10 transmit insertion, mode 10
    wrCfg(0, 8'h08);
    @(negedge clk);
    fifoTxData = 8'hA5; fifoTxValid = 1'b1; throttleReq = 1'b1; txReady = 1'b1; #1;
    check("R10", "mode 10 xoff load", txLoad, 1);
    check("R10", "mode 10 xoff char", txChar, XOFF_A);
    check("R10", "no pop on insert", fifoTxPop, 0);
    @(negedge clk); #1;
    check("R10", "data after insert", txChar, 8'hA5);
    check("R9", "pop when running", fifoTxPop, 1);
    txReady = 1'b0;

    // mode 11: two-character XON
    wrCfg(0, 8'h0C);
    @(negedge clk); throttleReq = 1'b0; txReady = 1'b1; #1;
    check("R10", "mode 11 first", txChar, XON_A);
    @(negedge clk); #1;
    check("R10", "mode 11 second", txChar, XON_B);
    check("R10", "mode 11 second no pop", fifoTxPop, 0);
    @(negedge clk); #1;
    check("R10", "mode 11 then data", fifoTxPop, 1);
    txReady = 1'b0;

    // mode 01: XOFF-B
    wrCfg(0, 8'h04);
    @(negedge clk); throttleReq = 1'b1; txReady = 1'b1; #1;
    check("R10", "mode 01 char", txChar, XOFF_B);
    check("R10", "mode 01 load", txLoad, 1);
    @(negedge clk); txReady = 1'b0;

    // R9 paused transmitter, insertion still allowed
    wrCfg(0, 8'h06);
    sendRx(XOFF_A);
    check("R9", "paused", txPaused, 1);
    @(negedge clk); txReady = 1'b1; #1;
    check("R9", "no load while paused", txLoad, 0);
    @(negedge clk); throttleReq = 1'b0; #1;
    check("R10", "insert while paused", txLoad, 1);
    check("R10", "insert char while paused", txChar, XON_B);
    @(negedge clk); #1;
    check("R9", "still held after insert", txLoad, 0);
    txReady = 1'b0;
    sendRx(XON_A);
    @(negedge clk); txReady = 1'b1; #1;
    check("R9", "resumed data", fifoTxPop, 1);
    @(negedge clk); txReady = 1'b0; fifoTxValid = 1'b0;
    got.delete();

    // R7 random pair-mode traffic against the bench model
    wrCfg(0, 8'h03);
    mPend = 0; mPaused = 1'b0; expQ.delete();
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [7:0] b;
      k = int'($urandom % 6);
      case (k)
        0: b = XON_A;
        1: b = XON_B;
        2: b = XOFF_A;
        3: b = XOFF_B;
        default: b = plainByte();
      endcase
      if (i % 50 == 25) wrCfg(0, ($urandom % 2) ? 8'h0F : 8'h03);
      modelByte(b);
      sendRx(b);
      check("R7", "random pause state", txPaused, mPaused);
    end
    check("R7", "random forward count", got.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < got.size(); i++)
      check("R7", "random forward byte", got[i], expQ[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule